// File: doc/BRIEF.md
# Programmable Dual Timebase Generator

This block gives a chip two independent periodic tick outputs, a slow one (channel 1) and a faster one (channel 2). Neither has an oscillator of its own. Both count single-cycle enable pulses from one of two reference strobes. One strobe stands for a 32768 Hz low-speed source and the other for a 27 MHz high-speed source. Software chooses the source and a rate code for each channel through one 16-bit control register on a simple write bus. Every write carries a per-bit write mask.

Each channel holds a modulo phase accumulator. On every enable from the selected reference, the accumulator adds the selected rate in hertz. It wraps at the reference frequency in hertz. Each wrap produces a one-cycle tick, so the average tick rate is exact even when the reference is not an integer multiple of the rate. A channel restarts from zero phase only when its own rate selection changes. A write to the clear register, one address above the control register, restarts both channels.

Top module: `dual_timebase`

## Requirements
- R1: After reset the control register reads 0x0000 and the low-speed source is selected. Channel 1 then runs at 8 Hz and channel 2 at 128 Hz. With a reference enable on every cycle, channel 1 ticks once per 4096 enables.
- R2: A write to the control address (offset 0) updates only the bits set in the write mask. Reading offset 0 returns the control register. Reading any other address, including the clear address, returns zero.
- R3: Control bit 4 selects the reference. A value of 0 counts the low-speed enable and a value of 1 counts the high-speed enable. Enables on the reference that is not selected have no effect on either tick output.
- R4: Control bits 1:0 select the channel 1 rate. With the low source, codes 0 to 3 give 8, 16, 32 and 64 Hz. With the high source they give 12 kHz, 24 kHz, 40 kHz and 40 kHz. After a restart, n counted enables produce floor(n·rate/ref) ticks.
- R5: Control bits 3:2 select the channel 2 rate. With the low source, codes 0 to 3 give 128, 256, 512 and 1024 Hz. With the high source they give 105, 210, 420 and 840 kHz. The same counting rule as in R4 applies.
- R6: A control write that changes bit 4 or bits 1:0 restarts channel 1 from zero phase. A control write that changes bit 4 or bits 3:2 restarts channel 2. A channel whose own selection bits are unchanged keeps its phase.
- R7: A control write that changes none of bits 4:0 leaves both running phases undisturbed. This covers writes of the same value and writes to the upper bits only.
- R8: Any write to the clear address (offset 1) zeroes both accumulators in that cycle. The next tick of each channel therefore comes a full period later.
- R9: A tick is high for exactly one clock cycle. It rises in the cycle after the counted reference enable that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_ref_en | input | 1 | One-cycle strobe of the low-speed reference |
| hi_ref_en | input | 1 | One-cycle strobe of the high-speed reference |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wmask | input | 16 | Per-bit write mask |
| bus_rdata | output | 16 | Read data for bus_addr |
| tick_slow | output | 1 | Channel 1 tick pulse |
| tick_fast | output | 1 | Channel 2 tick pulse |

## Verification
The bench targets the following corner cases and the fault each one exposes:

- **Fractional high-speed rates (105 kHz and 840 kHz), checked by counting ticks.** A divider that truncates the period to an integer drifts away from floor(n·rate/ref) within a few periods.
- **Writes that touch only the upper byte, or rewrite the same rate bits.** A design that restarts on every write moves the next tick later.
- **A change to one channel's code alone.** Restarting both channels would shift the other channel's tick.
- **Enables on the reference that is not selected.** If they leak through, ticks appear where none are due.
- **Per-bit masking.** A design that writes whole bytes corrupts neighbouring fields in the readback.

// File: rtl/dtb_pkg.sv
`timescale 1ns/1ps
package dtb_pkg;
    localparam int DW      = 16;
    localparam int NCH     = 2;
    localparam int SRC_BIT = 4;
    localparam int CODE_W  = 2;

    // rate in hertz for channel ch, source hi, code
    function automatic int unsigned rate_hz(input int ch, input logic hi,
                                            input logic [CODE_W-1:0] code);
        int unsigned r;
        if (ch == 0) begin
            if (hi) begin
                case (code)
                    2'd0:    r = 32'd12000;
                    2'd1:    r = 32'd24000;
                    default: r = 32'd40000;
                endcase
            end else begin
                r = 32'd8 << code;
            end
        end else begin
            if (hi) r = 32'd105000 << code;
            else    r = 32'd128 << code;
        end
        return r;
    endfunction
endpackage

// File: rtl/dtb_regs.sv
`timescale 1ns/1ps
module dtb_regs
    import dtb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     wmask,
    output logic [DW-1:0]     ctrl,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    restart
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CTRL_ADDR + 1);

    typedef struct packed {
        logic [DW-1:0] ctrl;
    } regs_t;

    regs_t         r_d, r_q;
    logic          ctrl_hit, clr_hit;
    logic [DW-1:0] merged, diff;

    always_comb begin
        r_d      = r_q;
        ctrl_hit = wr && (addr == CTRL_A);
        clr_hit  = wr && (addr == CLR_A);
        merged   = (r_q.ctrl & ~wmask) | (wdata & wmask);
        diff     = merged ^ r_q.ctrl;
        if (ctrl_hit) r_d.ctrl = merged;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_rst
        assign restart[ch] = clr_hit |
            (ctrl_hit & (diff[SRC_BIT] | (|diff[ch*CODE_W +: CODE_W])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl  = r_q.ctrl;
    assign rdata = (addr == CTRL_A) ? r_q.ctrl : '0;

    AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == CTRL_A) |=> ((ctrl & ~$past(wmask)) == ($past(ctrl) & ~$past(wmask)))); // R2
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == CTRL_A) |=> $stable(ctrl)); // R2
endmodule

// File: rtl/dtb_phase_acc.sv
`timescale 1ns/1ps
module dtb_phase_acc #(
    parameter int ACC_W     = 26,
    parameter int LO_REF_HZ = 32768,
    parameter int HI_REF_HZ = 27000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_en,
    input  logic             hi_en,
    input  logic             hi_sel,
    input  logic [ACC_W-1:0] inc,
    input  logic             restart,
    output logic             tick
);
    localparam logic [ACC_W:0] LO_MOD = (ACC_W+1)'(LO_REF_HZ);
    localparam logic [ACC_W:0] HI_MOD = (ACC_W+1)'(HI_REF_HZ);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_t;

    acc_t           s_d, s_q;
    logic           en;
    logic [ACC_W:0] modulus, sum;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        en       = hi_sel ? hi_en : lo_en;
        modulus  = hi_sel ? HI_MOD : LO_MOD;
        sum      = {1'b0, s_q.acc} + {1'b0, inc};
        if (restart) begin
            s_d.acc = '0;
        end else if (en) begin
            if (sum >= modulus) begin
                s_d.acc  = ACC_W'(sum - modulus);
                s_d.tick = 1'b1;
            end else begin
                s_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
    AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ($past(en) && !$past(restart))); // R3
    AST_PHASE_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, s_q.acc} < modulus)); // R4
endmodule

// File: rtl/dual_timebase.sv
`timescale 1ns/1ps
module dual_timebase
    import dtb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int LO_REF_HZ = 32768,
    parameter int HI_REF_HZ = 27000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_ref_en,
    input  logic              hi_ref_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_wmask,
    output logic [DW-1:0]     bus_rdata,
    output logic              tick_slow,
    output logic              tick_fast
);
    localparam int MAX_REF = (HI_REF_HZ > LO_REF_HZ) ? HI_REF_HZ : LO_REF_HZ;
    localparam int ACC_W   = $clog2(MAX_REF) + 1;

    logic [DW-1:0]  ctrl;
    logic [NCH-1:0] restart;
    logic [NCH-1:0] ticks;

    dtb_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .wmask(bus_wmask), .ctrl(ctrl),
        .rdata(bus_rdata), .restart(restart)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [ACC_W-1:0] inc;
        assign inc = ACC_W'(rate_hz(ch, ctrl[SRC_BIT], ctrl[ch*CODE_W +: CODE_W]));

        dtb_phase_acc #(.ACC_W(ACC_W), .LO_REF_HZ(LO_REF_HZ), .HI_REF_HZ(HI_REF_HZ)) u_acc (
            .clk(clk), .rst_n(rst_n), .lo_en(lo_ref_en), .hi_en(hi_ref_en),
            .hi_sel(ctrl[SRC_BIT]), .inc(inc), .restart(restart[ch]),
            .tick(ticks[ch])
        );

        AST_CODE_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ctrl[ch*CODE_W +: CODE_W]) |-> $past(restart[ch])); // R6
    end

    AST_SRC_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl[SRC_BIT]) |-> ($past(restart) == '1)); // R6

    assign tick_slow = ticks[0];
    assign tick_fast = ticks[1];
endmodule

// File: tb/dual_timebase_test.sv
`timescale 1ns/1ps
module dual_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lo_ref_en, hi_ref_en, bus_wr;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata, bus_wmask, bus_rdata;
    logic        tick_slow, tick_fast;

    always #10 clk = ~clk;

    dual_timebase uut (
        .clk(clk), .rst_n(rst_n), .lo_ref_en(lo_ref_en), .hi_ref_en(hi_ref_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .tick_slow(tick_slow), .tick_fast(tick_fast)
    );

    int      checks = 0, errors = 0;
    bit      done = 0;
    logic [15:0] m_ctrl;
    longint  m_acc [2];
    bit      exp_tick [2];
    string   tag;
    int      cnt1, cnt2, b2b;
    bit      prev1, prev2;

    function automatic longint tb_rate(int ch, bit hi, bit [1:0] code);
        if (ch == 0) begin
            if (!hi) return 64'd8 << code;
            case (code)
                2'd0:    return 12000;
                2'd1:    return 24000;
                default: return 40000;
            endcase
        end
        return hi ? (64'd105000 << code) : (64'd128 << code);
    endfunction

    task automatic check(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic model_edge(bit lo, bit hi, bit wr, bit [3:0] a, bit [15:0] d, bit [15:0] m);
        bit          src = m_ctrl[4];
        bit          en = src ? hi : lo;
        longint      modv = src ? 27000000 : 32768;
        logic [15:0] nc = m_ctrl;
        bit [1:0]    rs = 2'b00;
        if (wr && a == 4'd0) begin
            nc = (m_ctrl & ~m) | (d & m);
            for (int ch = 0; ch < 2; ch++)
                rs[ch] = (nc[4] != m_ctrl[4]) || (nc[2*ch +: 2] != m_ctrl[2*ch +: 2]);
        end
        if (wr && a == 4'd1) rs = 2'b11;
        for (int ch = 0; ch < 2; ch++) begin
            exp_tick[ch] = 0;
            if (rs[ch]) m_acc[ch] = 0;
            else if (en) begin
                longint s = m_acc[ch] + tb_rate(ch, src, m_ctrl[2*ch +: 2]);
                if (s >= modv) begin
                    m_acc[ch] = s - modv;
                    exp_tick[ch] = 1;
                end else m_acc[ch] = s;
            end
        end
        m_ctrl = nc;
    endtask

    task automatic drive(bit lo, bit hi, bit wr, bit [3:0] a, bit [15:0] d, bit [15:0] m);
        lo_ref_en = lo; hi_ref_en = hi; bus_wr = wr;
        bus_addr = a; bus_wdata = d; bus_wmask = m;
        model_edge(lo, hi, wr, a, d, m);
        @(negedge clk);
        check(tag, "tick_slow", tick_slow, exp_tick[0]);
        check(tag, "tick_fast", tick_fast, exp_tick[1]);
        if (tick_slow && prev1) b2b++;
        if (tick_fast && prev2) b2b++;
        prev1 = tick_slow; prev2 = tick_fast;
        cnt1 += int'(tick_slow); cnt2 += int'(tick_fast);
        bus_wr = 0;
    endtask

    task automatic run(bit lo, bit hi, int n);
        for (int i = 0; i < n; i++) drive(lo, hi, 0, 4'd0, 16'h0, 16'h0);
    endtask

    task automatic wr(bit [3:0] a, bit [15:0] d, bit [15:0] m);
        drive(0, 0, 1, a, d, m);
    endtask

    task automatic readback(string t);
        bus_wr = 0; bus_addr = 4'd0; #1;
        check(t, "ctrl readback", bus_rdata, m_ctrl);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst_n = 0; lo_ref_en = 0; hi_ref_en = 0; bus_wr = 0;
        bus_addr = 0; bus_wdata = 0; bus_wmask = 0;
        m_ctrl = 0; m_acc[0] = 0; m_acc[1] = 0;
        cnt1 = 0; cnt2 = 0; b2b = 0; prev1 = 0; prev2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        // R1 reset state
        check("R1", "reset ctrl", bus_rdata, 0);
        check("R1", "reset tick_slow", tick_slow, 0);
        check("R1", "reset tick_fast", tick_fast, 0);
        @(negedge clk);

        // R1 default rates, enable every cycle
        tag = "R1"; cnt1 = 0; cnt2 = 0;
        run(1, 0, 4200);
        check("R1", "8 Hz ticks in 4200 enables", cnt1, 1);
        check("R1", "128 Hz ticks in 4200 enables", cnt2, 16);

        // R2 masked writes
        tag = "R2";
        wr(4'd0, 16'hABCD, 16'hFF00); readback("R2");
        check("R2", "upper lane only", bus_rdata, 16'hAB00);
        wr(4'd0, 16'hFFFF, 16'h00E0); readback("R2");
        check("R2", "bits 7:5 only", bus_rdata, 16'hABE0);
        bus_addr = 4'd1; #1;
        check("R2", "clear address reads zero", bus_rdata, 0);
        wr(4'd0, 16'h0000, 16'hFFFF); readback("R2");

        // R4 R5 rate sweep with tick counts
        for (int src = 0; src < 2; src++) begin
            for (int code = 0; code < 4; code++) begin
                int n;
                longint ref_hz;
                tag = "R4 R5";
                wr(4'd1, 16'h0, 16'hFFFF);
                wr(4'd0, 16'(src * 16 + code * 4 + code), 16'hFFFF);
                n = src ? 2400 : (8192 >> code) + 50;
                ref_hz = src ? 27000000 : 32768;
                cnt1 = 0; cnt2 = 0;
                run(src == 0, src == 1, n);
                check("R4", "slow tick count", cnt1, (longint'(n) * tb_rate(0, src[0], code[1:0])) / ref_hz);
                check("R5", "fast tick count", cnt2, (longint'(n) * tb_rate(1, src[0], code[1:0])) / ref_hz);
            end
        end

        // R3 unselected reference ignored
        tag = "R3";
        wr(4'd0, 16'h001F, 16'hFFFF);
        cnt1 = 0; cnt2 = 0;
        run(1, 0, 3000);
        check("R3", "high source, low enables only: slow", cnt1, 0);
        check("R3", "high source, low enables only: fast", cnt2, 0);
        wr(4'd0, 16'h000F, 16'hFFFF);
        cnt1 = 0; cnt2 = 0;
        run(0, 1, 3000);
        check("R3", "low source, high enables only: slow", cnt1, 0);
        check("R3", "low source, high enables only: fast", cnt2, 0);

        // R7 writes not touching rate bits keep phase
        tag = "R7";
        wr(4'd0, 16'h0000, 16'hFFFF);
        wr(4'd1, 16'h0, 16'h0);
        cnt1 = 0;
        run(1, 0, 2000);
        wr(4'd0, 16'h5500, 16'hFF00);
        wr(4'd0, 16'h5500, 16'hFFFF);
        run(1, 0, 2150);
        check("R7", "slow tick kept phase", cnt1, 1);

        // R6 channel 2 code change only, channel 1 keeps phase
        tag = "R6";
        wr(4'd1, 16'h0, 16'h0);
        cnt1 = 0;
        run(1, 0, 3000);
        wr(4'd0, 16'h0008, 16'h000C);
        run(1, 0, 1150);
        check("R6", "slow tick unaffected by fast code", cnt1, 1);

        // R8 clear mid period delays next tick
        tag = "R8";
        cnt1 = 0;
        run(1, 0, 2000);
        wr(4'd1, 16'h1234, 16'h0000);
        run(1, 0, 4000);
        check("R8", "no slow tick before full period", cnt1, 0);
        run(1, 0, 200);
        check("R8", "slow tick after full period", cnt1, 1);

        // random mix of enables and writes
        tag = "R6 R7 R8";
        for (int i = 0; i < 30000; i++) begin
            bit lo = $urandom % 2, hi = $urandom % 2;
            if ($urandom % 200 == 0) begin
                bit [3:0]  a = 4'($urandom % 3);
                bit [15:0] d = 16'($urandom);
                bit [15:0] m;
                case ($urandom % 4)
                    0: m = 16'hFFFF;
                    1: m = 16'hFF00;
                    2: m = 16'h00FF;
                    default: m = 16'($urandom);
                endcase
                drive(lo, hi, 1, a, d, m);
                if (a == 4'd0) readback("R2");
            end else begin
                drive(lo, hi, 0, 4'd0, 16'h0, 16'h0);
            end
        end

        check("R9", "back-to-back tick cycles", b2b, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule